// File: doc/BRIEF.md
# Register Rename Map with History Log

This block is the register renaming unit of an out-of-order core. It keeps the speculative mapping from each architectural register to a physical register. Registers not in use wait in a FIFO free list. Every destination rename is written as one record into a circular history log. Each cycle a group of up to `W` instructions can be presented. Slot 0 is the oldest instruction in the group. For every valid slot the block returns these values in the same cycle:
- the newly allocated physical register,
- the physical register it displaces,
- the physical registers of both source operands.

The group is taken whole or not at all.

Retirement and recovery both use the history log. A commit bound retires log records from the oldest end and frees the physical register that each record displaced. A squash bound walks the log from the youngest end. For each record it writes the displaced register back into the map and frees the register that had been allocated. It does not restore a saved copy of the whole map. While this walk runs, `busy_o` is high and no renaming is accepted.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers ARCH_REGS to PHYS_REGS-1 in ascending order, so the first allocation returns ARCH_REGS. `busy_o` is low, and `stall_o` is low while no slot is valid.
- R2: When a group is accepted, the valid slots take registers from the head of the free list in FIFO order, from the lowest slot upward, and `ren_new_o[k]` shows the register given to slot k.
- R3: `ren_old_o[k]` is the register that the destination of slot k was mapped to just before that slot. If an older valid slot in the same group writes the same destination, this is that older slot's new register.
- R4: Source lookups of slot k see the map as it stands before slot k's own destination is renamed. The youngest older valid slot in the same group that writes that source overrides the map.
- R5: Let need be the number of valid slots, or 1 when none is valid. `stall_o` is high when fewer than need registers are free or fewer than need log records are unused. While stalled, no register is allocated, the map is not changed, and nothing is logged.
- R6: Up to W instructions are renamed per cycle, and a lower slot index is the older instruction.
- R7: After `commit_valid_i` with bound C, log records with sequence number at or below C are retired oldest first, one per cycle. The displaced register of each retired record is appended to the tail of the free list.
- R8: A `squash_valid_i` with bound S while `busy_o` is low raises `busy_o` in the next cycle. Records with sequence number above S are then undone youngest first, one per cycle. Each undo restores the displaced register in the map and appends the allocated register to the tail of the free list. `busy_o` falls one cycle after the last undo.
- R9: While `busy_o` or `squash_valid_i` is high, `stall_o` is high and no group is accepted. Retirement waits while `busy_o` is high.
- R10: `ren_fire_o` is high exactly when at least one slot is valid and `stall_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | W | Slot holds an instruction with a destination |
| ren_seq_i | input | W x SW | Sequence number per slot |
| ren_dst_i | input | W x AW | Architectural destination per slot |
| ren_src_a_i | input | W x AW | First architectural source per slot |
| ren_src_b_i | input | W x AW | Second architectural source per slot |
| ren_fire_o | output | 1 | Group accepted this cycle |
| stall_o | output | 1 | Group cannot be accepted this cycle |
| ren_new_o | output | W x PW | Newly allocated physical register per slot |
| ren_old_o | output | W x PW | Displaced physical register per slot |
| ren_src_a_o | output | W x PW | Physical register of the first source |
| ren_src_b_o | output | W x PW | Physical register of the second source |
| commit_valid_i | input | 1 | Load a new commit bound |
| commit_seq_i | input | SW | Commit bound: retire records at or below it |
| squash_valid_i | input | 1 | Start rollback |
| squash_seq_i | input | SW | Squash bound: undo records above it |
| busy_o | output | 1 | Rollback in progress |

## Verification
The assertions assume the following about the inputs:
- Sequence numbers rise with slot order and across accepted groups, and they never wrap.
- A squash is issued only while `busy_o` is low.
- The squash bound is never below the current commit bound, and the commit bound never moves backward.

The bench meets these conditions by construction. It draws every commit and squash bound from the interval between the current commit bound and the youngest sequence number issued. It issues a squash only while its own model shows the unit idle. After a squash it restarts sequence numbering just above the squash bound.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
  typedef enum logic {RR_RUN = 1'b0, RR_UNDO = 1'b1} rr_mode_e;

  function automatic int unsigned rr_wrap(int unsigned base, int unsigned off,
                                          int unsigned depth);
    return (base + off) % depth;
  endfunction
endpackage

// File: rtl/rr_free_list.sv
`timescale 1ns/1ps
module rr_free_list
  import rr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BASE  = 16,
  parameter int unsigned W     = 2,
  parameter int unsigned PW    = 5,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned NW    = $clog2(W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NW-1:0]          pop_n_i,
  input  logic                   push_i,
  input  logic [PW-1:0]          push_phys_i,
  output logic [W-1:0][PW-1:0]   peek_o,
  output logic [CW-1:0]          count_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] slot_q [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  always_comb begin
    for (int k = 0; k < W; k++) begin
      peek_o[k] = slot_q[IW'(rr_wrap(32'(head_q), 32'(k), DEPTH))];
    end
  end

  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= PW'(BASE + 32'(i));
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(DEPTH);
    end else begin
      if (push_i) begin
        slot_q[tail_q] <= push_phys_i;
        tail_q         <= IW'(rr_wrap(32'(tail_q), 1, DEPTH));
      end
      head_q  <= IW'(rr_wrap(32'(head_q), 32'(pop_n_i), DEPTH));
      count_q <= count_q + CW'(push_i) - CW'(pop_n_i);
    end
  end
endmodule

// File: rtl/rr_hist_buf.sv
`timescale 1ns/1ps
module rr_hist_buf
  import rr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 2,
  parameter int unsigned SW    = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned PW    = 5,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          push_i,
  input  logic [W-1:0][SW-1:0]  push_seq_i,
  input  logic [W-1:0][AW-1:0]  push_arch_i,
  input  logic [W-1:0][PW-1:0]  push_new_i,
  input  logic [W-1:0][PW-1:0]  push_old_i,
  input  logic                  retire_i,
  input  logic                  undo_i,
  output logic [SW-1:0]         head_seq_o,
  output logic [PW-1:0]         head_old_o,
  output logic [SW-1:0]         tail_seq_o,
  output logic [AW-1:0]         tail_arch_o,
  output logic [PW-1:0]         tail_new_o,
  output logic [PW-1:0]         tail_old_o,
  output logic [CW-1:0]         count_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(W + 1);

  typedef struct packed {
    logic [SW-1:0] seq;
    logic [AW-1:0] arch;
    logic [PW-1:0] np;
    logic [PW-1:0] op;
  } ent_t;

  ent_t          mem_q [DEPTH];
  logic [IW-1:0] head_q, tail_q, last_idx;
  logic [CW-1:0] count_q;
  logic [W-1:0][NW-1:0] rank;
  logic [NW-1:0] npush;

  always_comb begin
    logic [NW-1:0] acc;
    acc = '0;
    for (int k = 0; k < W; k++) begin
      rank[k] = acc;
      acc     = acc + NW'(push_i[k]);
    end
    npush = acc;
  end

  assign last_idx    = IW'(rr_wrap(32'(tail_q), DEPTH - 1, DEPTH));
  assign head_seq_o  = mem_q[head_q].seq;
  assign head_old_o  = mem_q[head_q].op;
  assign tail_seq_o  = mem_q[last_idx].seq;
  assign tail_arch_o = mem_q[last_idx].arch;
  assign tail_new_o  = mem_q[last_idx].np;
  assign tail_old_o  = mem_q[last_idx].op;
  assign count_o     = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      for (int k = 0; k < W; k++) begin
        if (push_i[k]) begin
          mem_q[IW'(rr_wrap(32'(tail_q), 32'(rank[k]), DEPTH))] <=
            '{seq: push_seq_i[k], arch: push_arch_i[k],
              np: push_new_i[k], op: push_old_i[k]};
        end
      end
      if (undo_i) tail_q <= last_idx;
      else        tail_q <= IW'(rr_wrap(32'(tail_q), 32'(npush), DEPTH));
      if (retire_i) head_q <= IW'(rr_wrap(32'(head_q), 1, DEPTH));
      count_q <= count_q + CW'(npush) - CW'(retire_i) - CW'(undo_i);
    end
  end
endmodule

// File: rtl/rr_map_table.sv
`timescale 1ns/1ps
module rr_map_table #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 2,
  parameter int unsigned AW   = 4,
  parameter int unsigned PW   = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_grp_i,
  input  logic [W-1:0]          valid_i,
  input  logic [W-1:0][AW-1:0]  dst_i,
  input  logic [W-1:0][AW-1:0]  src_a_i,
  input  logic [W-1:0][AW-1:0]  src_b_i,
  input  logic [W-1:0][PW-1:0]  new_i,
  output logic [W-1:0][PW-1:0]  old_o,
  output logic [W-1:0][PW-1:0]  src_a_o,
  output logic [W-1:0][PW-1:0]  src_b_o,
  input  logic                  undo_i,
  input  logic [AW-1:0]         undo_arch_i,
  input  logic [PW-1:0]         undo_phys_i
);
  logic [PW-1:0] map_q [NREG];

  // read map, then let older slots of the same group override in age order
  always_comb begin
    for (int k = 0; k < W; k++) begin
      old_o[k]   = map_q[dst_i[k]];
      src_a_o[k] = map_q[src_a_i[k]];
      src_b_o[k] = map_q[src_b_i[k]];
      for (int j = 0; j < k; j++) begin
        if (valid_i[j]) begin
          if (dst_i[j] == dst_i[k])   old_o[k]   = new_i[j];
          if (dst_i[j] == src_a_i[k]) src_a_o[k] = new_i[j];
          if (dst_i[j] == src_b_i[k]) src_b_o[k] = new_i[j];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) map_q[i] <= PW'(i);
    end else if (undo_i) begin
      map_q[undo_arch_i] <= undo_phys_i;
    end else if (wr_grp_i) begin
      for (int k = 0; k < W; k++) begin
        if (valid_i[k]) map_q[dst_i[k]] <= new_i[k];
      end
    end
  end
endmodule

// File: rtl/reg_rename_unit.sv
`timescale 1ns/1ps
module reg_rename_unit
  import rr_pkg::*;
#(
  parameter int unsigned W          = 2,
  parameter int unsigned ARCH_REGS  = 16,
  parameter int unsigned PHYS_REGS  = 32,
  parameter int unsigned HIST_DEPTH = 8,
  parameter int unsigned SW         = 16,
  // derived widths
  parameter int unsigned AW         = $clog2(ARCH_REGS),
  parameter int unsigned PW         = $clog2(PHYS_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          ren_valid_i,
  input  logic [W-1:0][SW-1:0]  ren_seq_i,
  input  logic [W-1:0][AW-1:0]  ren_dst_i,
  input  logic [W-1:0][AW-1:0]  ren_src_a_i,
  input  logic [W-1:0][AW-1:0]  ren_src_b_i,
  output logic                  ren_fire_o,
  output logic                  stall_o,
  output logic [W-1:0][PW-1:0]  ren_new_o,
  output logic [W-1:0][PW-1:0]  ren_old_o,
  output logic [W-1:0][PW-1:0]  ren_src_a_o,
  output logic [W-1:0][PW-1:0]  ren_src_b_o,
  input  logic                  commit_valid_i,
  input  logic [SW-1:0]         commit_seq_i,
  input  logic                  squash_valid_i,
  input  logic [SW-1:0]         squash_seq_i,
  output logic                  busy_o
);
  localparam int unsigned FL_DEPTH = PHYS_REGS - ARCH_REGS;
  localparam int unsigned FCW      = $clog2(FL_DEPTH + 1);
  localparam int unsigned HCW      = $clog2(HIST_DEPTH + 1);
  localparam int unsigned NW       = $clog2(W + 1);

  rr_mode_e      mode_q;
  logic [SW-1:0] sq_bound_q, cm_bound_q;
  logic          cm_have_q;

  logic [W-1:0][PW-1:0] fl_peek, new_phys, old_phys;
  logic [FCW-1:0]       fl_count;
  logic [HCW-1:0]       h_count;
  logic [SW-1:0]        head_seq, tail_seq;
  logic [PW-1:0]        head_old, tail_new, tail_old;
  logic [AW-1:0]        tail_arch;
  logic [W-1:0][NW-1:0] rank;
  logic [NW-1:0]        nvalid, need, pop_n;
  logic                 busy, short_fl, short_hist, fire;
  logic                 undo_do, retire_do, fl_push;
  logic [PW-1:0]        fl_push_phys;

  always_comb begin
    logic [NW-1:0] acc;
    acc = '0;
    for (int k = 0; k < W; k++) begin
      rank[k] = acc;
      acc     = acc + NW'(ren_valid_i[k]);
    end
    nvalid = acc;
  end

  always_comb begin
    for (int k = 0; k < W; k++) new_phys[k] = fl_peek[rank[k]];
  end

  assign need       = (nvalid == '0) ? NW'(1) : nvalid;
  assign busy       = (mode_q == RR_UNDO);
  assign short_fl   = 32'(fl_count) < 32'(need);
  assign short_hist = (32'(HIST_DEPTH) - 32'(h_count)) < 32'(need);
  assign stall_o    = busy | squash_valid_i | short_fl | short_hist;
  assign fire       = (|ren_valid_i) & ~stall_o;
  assign pop_n      = fire ? nvalid : '0;

  assign undo_do   = busy && (h_count != '0) && (tail_seq > sq_bound_q);
  assign retire_do = !busy && cm_have_q && (h_count != '0) &&
                     (head_seq <= cm_bound_q);
  assign fl_push      = undo_do | retire_do;
  assign fl_push_phys = busy ? tail_new : head_old;

  rr_free_list #(
    .DEPTH(FL_DEPTH), .BASE(ARCH_REGS), .W(W), .PW(PW), .CW(FCW), .NW(NW)
  ) u_free (
    .clk_i, .rst_ni,
    .pop_n_i    (pop_n),
    .push_i     (fl_push),
    .push_phys_i(fl_push_phys),
    .peek_o     (fl_peek),
    .count_o    (fl_count)
  );

  rr_map_table #(.NREG(ARCH_REGS), .W(W), .AW(AW), .PW(PW)) u_map (
    .clk_i, .rst_ni,
    .wr_grp_i   (fire),
    .valid_i    (ren_valid_i),
    .dst_i      (ren_dst_i),
    .src_a_i    (ren_src_a_i),
    .src_b_i    (ren_src_b_i),
    .new_i      (new_phys),
    .old_o      (old_phys),
    .src_a_o    (ren_src_a_o),
    .src_b_o    (ren_src_b_o),
    .undo_i     (undo_do),
    .undo_arch_i(tail_arch),
    .undo_phys_i(tail_old)
  );

  rr_hist_buf #(
    .DEPTH(HIST_DEPTH), .W(W), .SW(SW), .AW(AW), .PW(PW), .CW(HCW)
  ) u_hist (
    .clk_i, .rst_ni,
    .push_i     (fire ? ren_valid_i : '0),
    .push_seq_i (ren_seq_i),
    .push_arch_i(ren_dst_i),
    .push_new_i (new_phys),
    .push_old_i (old_phys),
    .retire_i   (retire_do),
    .undo_i     (undo_do),
    .head_seq_o (head_seq),
    .head_old_o (head_old),
    .tail_seq_o (tail_seq),
    .tail_arch_o(tail_arch),
    .tail_new_o (tail_new),
    .tail_old_o (tail_old),
    .count_o    (h_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= RR_RUN;
      sq_bound_q <= '0;
      cm_bound_q <= '0;
      cm_have_q  <= 1'b0;
    end else begin
      if (!busy && squash_valid_i) begin
        mode_q     <= RR_UNDO;
        sq_bound_q <= squash_seq_i;
      end else if (busy && !undo_do) begin
        mode_q <= RR_RUN;
      end
      if (commit_valid_i) begin
        cm_bound_q <= commit_seq_i;
        cm_have_q  <= 1'b1;
      end
    end
  end

  assign ren_fire_o = fire;
  assign ren_new_o  = new_phys;
  assign ren_old_o  = old_phys;
  assign busy_o     = busy;
endmodule

// File: rtl/rr_rename_checker.sv
`timescale 1ns/1ps
module rr_rename_checker #(
  parameter int unsigned W  = 2,
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [W-1:0]          ren_valid_i,
  input logic [W-1:0][AW-1:0]  ren_dst_i,
  input logic [W-1:0][AW-1:0]  ren_src_a_i,
  input logic                  ren_fire_o,
  input logic [W-1:0][PW-1:0]  ren_new_o,
  input logic [W-1:0][PW-1:0]  ren_old_o,
  input logic [W-1:0][PW-1:0]  ren_src_a_o,
  input logic                  squash_valid_i,
  input logic                  busy_o
);
  assert_squash_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i && !busy_o |=> busy_o);

  assert_busy_no_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ren_fire_o);

  assert_squash_no_fire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i |-> !ren_fire_o);

  for (genvar k = 0; k < W; k++) begin : g_slot
    assert_new_not_old_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ren_fire_o && ren_valid_i[k] |-> ren_new_o[k] != ren_old_o[k]);
  end

  for (genvar k = 1; k < W; k++) begin : g_pair
    assert_distinct_alloc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ren_fire_o && ren_valid_i[k] && ren_valid_i[k-1]
      |-> ren_new_o[k] != ren_new_o[k-1]);

    assert_old_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ren_fire_o && ren_valid_i[k] && ren_valid_i[k-1] &&
      ren_dst_i[k] == ren_dst_i[k-1] |-> ren_old_o[k] == ren_new_o[k-1]);

    assert_src_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ren_fire_o && ren_valid_i[k] && ren_valid_i[k-1] &&
      ren_src_a_i[k] == ren_dst_i[k-1] |-> ren_src_a_o[k] == ren_new_o[k-1]);
  end
endmodule

bind reg_rename_unit rr_rename_checker #(.W(W), .AW(AW), .PW(PW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ren_valid_i   (ren_valid_i),
  .ren_dst_i     (ren_dst_i),
  .ren_src_a_i   (ren_src_a_i),
  .ren_fire_o    (ren_fire_o),
  .ren_new_o     (ren_new_o),
  .ren_old_o     (ren_old_o),
  .ren_src_a_o   (ren_src_a_o),
  .squash_valid_i(squash_valid_i),
  .busy_o        (busy_o)
);

// File: tb/reg_rename_unit_tb.sv
`timescale 1ns/1ps
module reg_rename_unit_tb;
  localparam int W = 2, ARCH = 16, PHYS = 32, HIST = 8, SW = 16;
  localparam int AW = $clog2(ARCH), PW = $clog2(PHYS);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]          ren_valid_i = '0;
  logic [W-1:0][SW-1:0]  ren_seq_i = '0;
  logic [W-1:0][AW-1:0]  ren_dst_i = '0, ren_src_a_i = '0, ren_src_b_i = '0;
  logic                  ren_fire_o, stall_o, busy_o;
  logic [W-1:0][PW-1:0]  ren_new_o, ren_old_o, ren_src_a_o, ren_src_b_o;
  logic                  commit_valid_i = 1'b0, squash_valid_i = 1'b0;
  logic [SW-1:0]         commit_seq_i = '0, squash_seq_i = '0;

  reg_rename_unit #(.W(W), .ARCH_REGS(ARCH), .PHYS_REGS(PHYS),
                    .HIST_DEPTH(HIST), .SW(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i, .ren_seq_i, .ren_dst_i, .ren_src_a_i, .ren_src_b_i,
    .ren_fire_o, .stall_o, .ren_new_o, .ren_old_o, .ren_src_a_o, .ren_src_b_o,
    .commit_valid_i, .commit_seq_i, .squash_valid_i, .squash_seq_i, .busy_o);

  typedef struct {int seq; int arch; int np; int op;} he_t;
  int  map_m [ARCH];
  int  fq[$];
  he_t hq[$];
  bit  busy_m, cm_have;
  int  sq_b, cm_b, next_seq;
  int  checks, errors;

  logic [W-1:0] v_in;
  int  dst_in [W], sa_in [W], sb_in [W];
  bit  cm_v, sq_v, r1_probe;
  int  cm_s, sq_s;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cycle();
    int n, need, r, seqs[W], np[W], op[W], pa[W], pb[W];
    bit stall_e, fire_e, rt, ud;
    he_t e;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < W; k++) begin
      seqs[k] = v_in[k] ? next_seq + n : 0;
      if (v_in[k]) n++;
      ren_seq_i[k]   = SW'(seqs[k]);
      ren_dst_i[k]   = AW'(dst_in[k]);
      ren_src_a_i[k] = AW'(sa_in[k]);
      ren_src_b_i[k] = AW'(sb_in[k]);
    end
    ren_valid_i    = v_in;
    commit_valid_i = cm_v;
    commit_seq_i   = SW'(cm_s);
    squash_valid_i = sq_v;
    squash_seq_i   = SW'(sq_s);
    #1;
    need    = (n == 0) ? 1 : n;
    stall_e = busy_m || sq_v || fq.size() < need || (HIST - hq.size()) < need;
    fire_e  = (n > 0) && !stall_e;
    chk(busy_o == busy_m, "R8 R9 busy", int'(busy_o), int'(busy_m));
    chk(stall_o == stall_e, "R5 R9 stall", int'(stall_o), int'(stall_e));
    chk(ren_fire_o == fire_e, "R10 fire", int'(ren_fire_o), int'(fire_e));
    if (r1_probe) begin
      chk(int'(ren_new_o[0]) == ARCH, "R1 first alloc", int'(ren_new_o[0]), ARCH);
      chk(int'(ren_old_o[0]) == dst_in[0], "R1 identity map", int'(ren_old_o[0]), dst_in[0]);
      chk(int'(ren_src_a_o[0]) == sa_in[0], "R1 identity src", int'(ren_src_a_o[0]), sa_in[0]);
    end
    if (fire_e) begin
      r = 0;
      for (int k = 0; k < W; k++) begin
        if (v_in[k]) begin
          np[k] = fq[r]; r++;
          op[k] = map_m[dst_in[k]];
          pa[k] = map_m[sa_in[k]];
          pb[k] = map_m[sb_in[k]];
          for (int j = 0; j < k; j++) begin
            if (v_in[j]) begin
              if (dst_in[j] == dst_in[k]) op[k] = np[j];
              if (dst_in[j] == sa_in[k])  pa[k] = np[j];
              if (dst_in[j] == sb_in[k])  pb[k] = np[j];
            end
          end
          chk(int'(ren_new_o[k]) == np[k], "R2 R6 R7 R8 new", int'(ren_new_o[k]), np[k]);
          chk(int'(ren_old_o[k]) == op[k], "R3 R6 old", int'(ren_old_o[k]), op[k]);
          chk(int'(ren_src_a_o[k]) == pa[k], "R4 src a", int'(ren_src_a_o[k]), pa[k]);
          chk(int'(ren_src_b_o[k]) == pb[k], "R4 src b", int'(ren_src_b_o[k]), pb[k]);
        end
      end
    end
    // model next state
    rt = !busy_m && cm_have && hq.size() > 0 && hq[0].seq <= cm_b;
    ud = busy_m && hq.size() > 0 && hq[$].seq > sq_b;
    if (fire_e) begin
      repeat (n) void'(fq.pop_front());
      for (int k = 0; k < W; k++) begin
        if (v_in[k]) begin
          hq.push_back('{seq: seqs[k], arch: dst_in[k], np: np[k], op: op[k]});
          map_m[dst_in[k]] = np[k];
        end
      end
      next_seq += n;
    end
    if (rt) begin
      e = hq.pop_front();
      fq.push_back(e.op);
    end
    if (ud) begin
      e = hq.pop_back();
      map_m[e.arch] = e.op;
      fq.push_back(e.np);
    end
    if (!busy_m && sq_v) begin
      busy_m = 1'b1; sq_b = sq_s; next_seq = sq_s + 1;
    end else if (busy_m && !ud) begin
      busy_m = 1'b0;
    end
    if (cm_v) begin
      cm_b = cm_s; cm_have = 1'b1;
    end
  endtask

  task automatic idle_inputs();
    v_in = '0; cm_v = 0; sq_v = 0; r1_probe = 0;
    for (int k = 0; k < W; k++) begin
      dst_in[k] = 0; sa_in[k] = 0; sb_in[k] = 0;
    end
  endtask

  task automatic rand_inputs();
    int lo, hi;
    idle_inputs();
    v_in = W'($urandom);
    for (int k = 0; k < W; k++) begin
      dst_in[k] = int'($urandom % ARCH);
      sa_in[k]  = int'($urandom % ARCH);
      sb_in[k]  = int'($urandom % ARCH);
    end
    lo = cm_have ? cm_b : 0;
    hi = next_seq - 1;
    if (!busy_m && ($urandom % 16) == 0) begin
      sq_v = 1;
      sq_s = lo + int'($urandom % 32'(hi - lo + 1));
      hi   = sq_s;
    end
    if (($urandom % 3) == 0) begin
      cm_v = 1;
      cm_s = lo + int'($urandom % 32'(hi - lo + 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < ARCH; i++) map_m[i] = i;
    for (int i = ARCH; i < PHYS; i++) fq.push_back(i);
    next_seq = 1; cm_b = 0; sq_b = 0; cm_have = 0; busy_m = 0;
    checks = 0; errors = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    chk(stall_o == 1'b0, "R1 reset stall", int'(stall_o), 0);

    // R1: identity map and first allocation
    idle_inputs(); v_in = 2'b01; dst_in[0] = 2; sa_in[0] = 7; sb_in[0] = 9; r1_probe = 1;
    run_cycle();
    // R3 R4: same destination in both slots, younger reads older
    idle_inputs(); v_in = 2'b11; dst_in[0] = 3; dst_in[1] = 3;
    sa_in[0] = 3; sa_in[1] = 3; sb_in[1] = 2;
    run_cycle();
    // R5: fill the history log without commits until it stalls
    for (int i = 0; i < 4; i++) begin
      idle_inputs(); v_in = 2'b11; dst_in[0] = i; dst_in[1] = i + 4; sa_in[1] = i;
      run_cycle();
    end
    idle_inputs(); v_in = 2'b01; dst_in[0] = 9; run_cycle();
    idle_inputs(); v_in = 2'b01; dst_in[0] = 10; run_cycle();
    // R7: retire everything
    idle_inputs(); cm_v = 1; cm_s = next_seq - 1; run_cycle();
    idle_inputs();
    for (int i = 0; i < 12; i++) run_cycle();
    // R8: rename three groups then squash back to the first
    for (int i = 0; i < 3; i++) begin
      idle_inputs(); v_in = 2'b11; dst_in[0] = 5; dst_in[1] = 6 + i; run_cycle();
    end
    idle_inputs(); sq_v = 1; sq_s = next_seq - 5; run_cycle();
    idle_inputs();
    for (int i = 0; i < 8; i++) run_cycle();

    for (int i = 0; i < 4000; i++) begin
      rand_inputs();
      run_cycle();
    end
    idle_inputs(); cm_v = 1; cm_s = next_seq - 1; run_cycle();
    idle_inputs();
    for (int i = 0; i < 12; i++) run_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule